// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Maintenance Commands

This block holds 64 address-translation entries, each a pair of 32-bit words. The high word carries a virtual page number in bits [31:12]. The low word carries a page frame number in bits [31:12] plus four flag bits. A combinational lookup port compares a virtual address against every entry in parallel. The lowest-numbered matching entry wins. The port returns the physical address, the flags and a fault class.

Four maintenance commands act on the entries:

- indexed read
- indexed write
- random write
- probe

They work against an index word, a high word and a low word, which are presented on input ports. Results come back on registered output ports one edge after the strobe.

Random writes take their slot from a free-running down counter. The counter never points at the eight lowest entries, so those entries stay pinned for translations that must survive replacement.

Top module: `tlb_xlate_top`

## Requirements
- R1: While reset is asserted and after it is released, every entry reads back as zero and `rand_idx_o` is 63. `rd_valid_o` and `pr_valid_o` are low until a command is issued.
- R2: `rand_idx_o` decrements by one on every clock edge and moves from 8 to 63. It always lies in the range 8 to 63.
- R3: Command code 1 (indexed write) with `cmd_valid_i` high stores `hi_i` and `lo_i` on that clock edge. The entry written is the one numbered by `idx_i[13:8]`.
- R4: Command code 0 (indexed read) makes `rd_valid_o` high for one cycle after the strobe edge. In that cycle `rd_hi_o` and `rd_lo_o` carry the entry numbered by `idx_i[13:8]`.
- R5: Command code 2 (random write) stores `hi_i` and `lo_i` into the entry given by `rand_idx_o` at the strobe edge. Entries 0 to 7 are never changed by it.
- R6: Command code 3 (probe) makes `pr_valid_o` high for one cycle. If some entry has a high word equal to `hi_i` and a low word equal to `lo_i`, then `pr_index_o` is the lowest such entry number placed in bits [13:8], with all other bits zero.
- R7: A probe that finds no such entry returns `idx_i` with bit 31 set on `pr_index_o`.
- R8: A lookup matches an entry when its high word bits [31:12] equal `va_i[31:12]`. The lowest matching entry is used. `pa_o` is that entry's low word bits [31:12] followed by `va_i[11:0]`, and `pa_o` is zero when nothing matches.
- R9: `fault_o` encodes the lookup outcome:
  - 1 when no entry matches.
  - 2 for a read, or 3 for a write, when the matched entry's valid bit (low word bit 9) is clear.
  - 4 for a write to a valid entry whose write-enable bit (low word bit 10) is clear.
  - 0 otherwise.
- R10: `global_o` and `nocache_o` show bit 8 and bit 11 of the matched entry's low word. Both are zero when no entry matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid_i | input | 1 | Maintenance command strobe |
| cmd_op_i | input | 2 | 0 read, 1 indexed write, 2 random write, 3 probe |
| idx_i | input | 32 | Index word; entry number in bits [13:8] |
| hi_i | input | 32 | High word for writes and probe |
| lo_i | input | 32 | Low word for writes and probe |
| rd_valid_o | output | 1 | Read result valid |
| rd_hi_o | output | 32 | Read result high word |
| rd_lo_o | output | 32 | Read result low word |
| pr_valid_o | output | 1 | Probe result valid |
| pr_index_o | output | 32 | Probe result index word |
| rand_idx_o | output | 6 | Current replacement slot |
| va_i | input | 32 | Lookup virtual address |
| wr_i | input | 1 | Lookup is a write |
| hit_o | output | 1 | Lookup matched an entry |
| pa_o | output | 32 | Lookup physical address |
| fault_o | output | 3 | Lookup fault class |
| global_o | output | 1 | Global flag of matched entry |
| nocache_o | output | 1 | Non-cacheable flag of matched entry |

## Verification
The embedded properties cover the following on every cycle:
- the replacement counter's range and step, including the move from 8 to 63;
- a random write never landing in the pinned slots;
- a written word appearing in its entry on the next cycle;
- the result pulses following their strobes;
- probe misses setting bit 31;
- a fault-free lookup always being a match that keeps the page offset.

The directed scenarios are the only way to show the value-level results. These are:
- which entry wins when several share a page or a probe pair;
- the exact frame and flag values on lookups;
- that the pinned entries still hold zero after a long burst of random writes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WIDX  = 2'd1,
    OP_WRAND = 2'd2,
    OP_PROBE = 2'd3
  } tlb_op_e;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_NOMATCH   = 3'd1,
    FLT_LOAD_INV  = 3'd2,
    FLT_STORE_INV = 3'd3,
    FLT_MOD       = 3'd4
  } tlb_fault_e;

  localparam int unsigned BIT_GLOBAL  = 8;
  localparam int unsigned BIT_VALID   = 9;
  localparam int unsigned BIT_WREN    = 10;
  localparam int unsigned BIT_NOCACHE = 11;
endpackage

// File: rtl/tlb_rand_ctr.sv
module tlb_rand_ctr #(
  parameter int unsigned N_ENT = 64,
  parameter int unsigned WIRED = 8,
  localparam int unsigned IW = $clog2(N_ENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [IW-1:0] rand_o
);
  localparam logic [IW-1:0] TOP = IW'(N_ENT - 1);
  localparam logic [IW-1:0] LOW = IW'(WIRED);

  logic [IW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == LOW) ? TOP : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= TOP;
    else        cnt_q <= cnt_d;
  end

  assign rand_o = cnt_q;

  p_rand_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= LOW) && (cnt_q <= TOP));
  p_rand_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LOW) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_rand_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LOW) |=> (cnt_q == TOP));
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int unsigned N_ENT = 64,
  parameter int unsigned W     = 32,
  localparam int unsigned IW = $clog2(N_ENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [W-1:0]  whi_i,
  input  logic [W-1:0]  wlo_i,
  output logic [W-1:0]  hi_o [N_ENT],
  output logic [W-1:0]  lo_o [N_ENT]
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic         en;
    logic [W-1:0] hi_q, lo_q;
    assign en = we_i && (waddr_i == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (en) begin
        hi_q <= whi_i;
        lo_q <= wlo_i;
      end
    end
    assign hi_o[g] = hi_q;
    assign lo_o[g] = lo_q;
  end

  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (hi_o[$past(waddr_i)] == $past(whi_i)) &&
             (lo_o[$past(waddr_i)] == $past(wlo_i)));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENT = 64,
  parameter int unsigned W     = 32,
  parameter int unsigned PG    = 12,
  localparam int unsigned IW = $clog2(N_ENT)
) (
  input  logic [W-1:0]  ent_hi_i [N_ENT],
  input  logic [W-1:0]  ent_lo_i [N_ENT],
  input  logic [W-1:0]  va_i,
  input  logic          wr_i,
  input  logic [W-1:0]  pr_hi_i,
  input  logic [W-1:0]  pr_lo_i,
  output logic          hit_o,
  output logic [W-1:0]  pa_o,
  output tlb_fault_e    fault_o,
  output logic          global_o,
  output logic          nocache_o,
  output logic          pr_hit_o,
  output logic [IW-1:0] pr_idx_o
);
  logic [IW-1:0] lk_idx;
  logic [W-1:0]  sel_lo;

  always_comb begin
    hit_o    = 1'b0;
    lk_idx   = '0;
    pr_hit_o = 1'b0;
    pr_idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (ent_hi_i[i][W-1:PG] == va_i[W-1:PG]) begin
        hit_o  = 1'b1;
        lk_idx = IW'(i);
      end
      if ((ent_hi_i[i] == pr_hi_i) && (ent_lo_i[i] == pr_lo_i)) begin
        pr_hit_o = 1'b1;
        pr_idx_o = IW'(i);
      end
    end
  end

  always_comb begin
    sel_lo = hit_o ? ent_lo_i[lk_idx] : '0;
    pa_o      = hit_o ? {sel_lo[W-1:PG], va_i[PG-1:0]} : '0;
    global_o  = sel_lo[BIT_GLOBAL];
    nocache_o = sel_lo[BIT_NOCACHE];
    if (!hit_o)                       fault_o = FLT_NOMATCH;
    else if (!sel_lo[BIT_VALID])      fault_o = wr_i ? FLT_STORE_INV : FLT_LOAD_INV;
    else if (wr_i && !sel_lo[BIT_WREN]) fault_o = FLT_MOD;
    else                              fault_o = FLT_NONE;
  end

  always_comb begin
    p_ok_needs_hit_r9: assert (fault_o != FLT_NONE || hit_o);
    p_offset_kept_r8: assert (!hit_o || pa_o[PG-1:0] == va_i[PG-1:0]);
  end
endmodule

// File: rtl/tlb_xlate_top.sv
module tlb_xlate_top
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENT   = 64,
  parameter int unsigned WIRED   = 8,
  parameter int unsigned W       = 32,
  parameter int unsigned PG      = 12,
  parameter int unsigned IDX_LSB = 8,
  localparam int unsigned IW = $clog2(N_ENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [W-1:0]  idx_i,
  input  logic [W-1:0]  hi_i,
  input  logic [W-1:0]  lo_i,
  output logic          rd_valid_o,
  output logic [W-1:0]  rd_hi_o,
  output logic [W-1:0]  rd_lo_o,
  output logic          pr_valid_o,
  output logic [W-1:0]  pr_index_o,
  output logic [IW-1:0] rand_idx_o,
  input  logic [W-1:0]  va_i,
  input  logic          wr_i,
  output logic          hit_o,
  output logic [W-1:0]  pa_o,
  output logic [2:0]    fault_o,
  output logic          global_o,
  output logic          nocache_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tlb_op_e       op;
  logic          is_rd, is_wi, is_wr, is_pr;
  logic [IW-1:0] sel_idx, waddr;
  logic          we;
  logic [W-1:0]  ent_hi [N_ENT];
  logic [W-1:0]  ent_lo [N_ENT];
  logic          pr_hit;
  logic [IW-1:0] pr_idx;
  tlb_fault_e    flt;

  assign op      = tlb_op_e'(cmd_op_i);
  assign is_rd   = cmd_valid_i && (op == OP_READ);
  assign is_wi   = cmd_valid_i && (op == OP_WIDX);
  assign is_wr   = cmd_valid_i && (op == OP_WRAND);
  assign is_pr   = cmd_valid_i && (op == OP_PROBE);
  assign sel_idx = idx_i[IDX_LSB +: IW];
  assign we      = is_wi || is_wr;
  assign waddr   = is_wr ? rand_idx_o : sel_idx;

  tlb_rand_ctr #(.N_ENT(N_ENT), .WIRED(WIRED)) i_rand (
    .clk(clk), .rst_n(rst_int_n), .rand_o(rand_idx_o));

  tlb_store #(.N_ENT(N_ENT), .W(W)) i_store (
    .clk(clk), .rst_n(rst_int_n), .we_i(we), .waddr_i(waddr),
    .whi_i(hi_i), .wlo_i(lo_i), .hi_o(ent_hi), .lo_o(ent_lo));

  tlb_match #(.N_ENT(N_ENT), .W(W), .PG(PG)) i_match (
    .ent_hi_i(ent_hi), .ent_lo_i(ent_lo), .va_i(va_i), .wr_i(wr_i),
    .pr_hi_i(hi_i), .pr_lo_i(lo_i), .hit_o(hit_o), .pa_o(pa_o),
    .fault_o(flt), .global_o(global_o), .nocache_o(nocache_o),
    .pr_hit_o(pr_hit), .pr_idx_o(pr_idx));

  assign fault_o = flt;

  // response next-state
  logic [W-1:0] pr_index_d;
  always_comb begin
    pr_index_d = pr_hit ? (W'(pr_idx) << IDX_LSB) : (idx_i | (W'(1) << (W - 1)));
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_valid_o <= 1'b0;
      pr_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= is_rd;
      pr_valid_o <= is_pr;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_hi_o <= '0;
      rd_lo_o <= '0;
    end else if (is_rd) begin
      rd_hi_o <= ent_hi[sel_idx];
      rd_lo_o <= ent_lo[sel_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  pr_index_o <= '0;
    else if (is_pr)  pr_index_o <= pr_index_d;
  end

  p_wired_safe_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    is_wr |-> (waddr >= IW'(WIRED)));
  p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    is_rd |=> rd_valid_o);
  p_probe_hit_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (is_pr && pr_hit) |=> pr_valid_o && !pr_index_o[W-1] &&
                          (pr_index_o[IDX_LSB +: IW] == $past(pr_idx)));
  p_probe_miss_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (is_pr && !pr_hit) |=> pr_valid_o && pr_index_o[W-1]);
endmodule

// File: tb/test_tlb_xlate_top.sv
module test_tlb_xlate_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [31:0] idx, hi, lo, va;
  logic        wr;
  logic        rd_valid, pr_valid, hit, gflag, ncflag;
  logic [31:0] rd_hi, rd_lo, pr_index, pa;
  logic [5:0]  rand_idx;
  logic [2:0]  fault;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_hi [64];
  logic [31:0] m_lo [64];

  always #10 clk = ~clk;

  tlb_xlate_top i_tlb_xlate_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .idx_i(idx), .hi_i(hi), .lo_i(lo), .rd_valid_o(rd_valid),
    .rd_hi_o(rd_hi), .rd_lo_o(rd_lo), .pr_valid_o(pr_valid),
    .pr_index_o(pr_index), .rand_idx_o(rand_idx), .va_i(va), .wr_i(wr),
    .hit_o(hit), .pa_o(pa), .fault_o(fault), .global_o(gflag),
    .nocache_o(ncflag));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [31:0] ix, input logic [31:0] h,
                     input logic [31:0] l, output logic [5:0] slot);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; idx = ix; hi = h; lo = l;
    slot = rand_idx;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wr_idx(input int e, input logic [31:0] h, input logic [31:0] l);
    logic [5:0] s;
    cmd(2'd1, 32'(e) << 8, h, l, s);
    m_hi[e] = h; m_lo[e] = l;
  endtask

  task automatic rd_check(input int e, input string tag);
    logic [5:0] s;
    cmd(2'd0, 32'(e) << 8, 32'h0, 32'h0, s);
    chk(rd_valid == 1'b1, tag, {31'b0, rd_valid}, 32'h1);
    chk(rd_hi == m_hi[e], tag, rd_hi, m_hi[e]);
    chk(rd_lo == m_lo[e], tag, rd_lo, m_lo[e]);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; idx = '0; hi = '0; lo = '0;
    va = 32'h0000_0000; wr = 1'b0;
    for (int i = 0; i < 64; i++) begin m_hi[i] = '0; m_lo[i] = '0; end
    repeat (3) @(negedge clk);
    chk(rand_idx == 6'd63, "R1 rand at reset", 32'(rand_idx), 32'd63);
    chk(!rd_valid && !pr_valid, "R1 no pulses", {30'b0, rd_valid, pr_valid}, 32'h0);
    chk(fault == 3'd2, "R1 zero entries fault", 32'(fault), 32'd2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!rd_valid && !pr_valid, "R1 quiet after release", {30'b0, rd_valid, pr_valid}, 32'h0);
    rd_check(5, "R1 entry 5 zero");
    rd_check(63, "R1 entry 63 zero");
  endtask

  task automatic t_rand_seq;
    logic [5:0] prev, exp;
    @(negedge clk);
    prev = rand_idx;
    for (int c = 0; c < 130; c++) begin
      @(negedge clk);
      exp = (prev == 6'd8) ? 6'd63 : prev - 6'd1;
      chk(rand_idx == exp, "R2 counter step", 32'(rand_idx), 32'(exp));
      prev = rand_idx;
    end
  endtask

  task automatic t_write_read;
    wr_idx(0, 32'hCAFE_0000, 32'h1234_5F00);
    wr_idx(63, 32'hDEAD_B000, 32'h0BAD_0700);
    wr_idx(17, 32'h0101_1000, 32'h0202_2600);
    rd_check(0, "R3 R4 entry 0");
    rd_check(63, "R3 R4 entry 63");
    rd_check(17, "R3 R4 entry 17");
    @(negedge clk);
    chk(!rd_valid, "R4 single pulse", {31'b0, rd_valid}, 32'h0);
  endtask

  task automatic t_random_write;
    logic [5:0] s;
    logic [31:0] h, l;
    for (int k = 0; k < 70; k++) begin
      h = 32'h0F00_0000 + (32'(k) << 12);
      l = 32'h00A0_0000 + (32'(k) << 12) + 32'h200;
      cmd(2'd2, 32'h0, h, l, s);
      chk(s >= 6'd8, "R5 slot above wired", 32'(s), 32'd8);
      m_hi[s] = h; m_lo[s] = l;
      if (k == 69) rd_check(int'(s), "R5 random entry content");
    end
    for (int e = 1; e < 8; e++) rd_check(e, "R5 wired entries untouched");
    rd_check(0, "R5 wired entry 0 untouched");
  endtask

  task automatic t_probe;
    logic [5:0] s;
    wr_idx(20, 32'h5555_6000, 32'h7777_8600);
    wr_idx(10, 32'h5555_6000, 32'h7777_8600);
    cmd(2'd3, 32'h0000_1234, 32'h5555_6000, 32'h7777_8600, s);
    chk(pr_valid == 1'b1, "R6 probe pulse", {31'b0, pr_valid}, 32'h1);
    chk(pr_index == 32'h0000_0A00, "R6 lowest probe hit", pr_index, 32'h0000_0A00);
    cmd(2'd3, 32'h0000_1234, 32'h5555_6000, 32'h7777_8601, s);
    chk(pr_index == 32'h8000_1234, "R7 probe miss", pr_index, 32'h8000_1234);
  endtask

  task automatic look(input logic [31:0] a, input bit w, input logic [31:0] epa,
                      input logic [2:0] ef, input bit eg, input bit en, input string tag);
    @(negedge clk);
    va = a; wr = w;
    #1;
    chk(pa == epa, tag, pa, epa);
    chk(fault == ef, tag, 32'(fault), 32'(ef));
    chk({gflag, ncflag} == {eg, en}, tag, {30'b0, gflag, ncflag}, {30'b0, eg, en});
  endtask

  task automatic t_lookup;
    wr_idx(30, 32'h1234_5000, 32'hABCD_E700);
    wr_idx(31, 32'h2222_2000, 32'h3333_3200);
    wr_idx(32, 32'h4444_4000, 32'h5555_5800);
    look(32'h1234_5678, 1'b0, 32'hABCD_E678, 3'd0, 1'b1, 1'b0, "R8 R10 read hit");
    look(32'h1234_5FFF, 1'b1, 32'hABCD_EFFF, 3'd0, 1'b1, 1'b0, "R9 write ok");
    look(32'h5555_6ABC, 1'b0, 32'h7777_8ABC, 3'd0, 1'b0, 1'b0, "R8 lowest match");
    look(32'h2222_2010, 1'b0, 32'h3333_3010, 3'd0, 1'b0, 1'b0, "R9 read clean");
    look(32'h2222_2010, 1'b1, 32'h3333_3010, 3'd4, 1'b0, 1'b0, "R9 modified");
    look(32'h4444_4004, 1'b0, 32'h5555_5004, 3'd2, 1'b0, 1'b1, "R9 R10 load invalid");
    look(32'h4444_4004, 1'b1, 32'h5555_5004, 3'd3, 1'b0, 1'b1, "R9 store invalid");
    look(32'h7777_7000, 1'b0, 32'h0, 3'd1, 1'b0, 1'b0, "R9 R10 no match");
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_rand_seq;
        t_write_read;
        t_random_write;
        t_probe;
        t_lookup;
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule